// File: doc/BRIEF.md
# Per-Port Endianness Mode Resolver

This block decides the byte ordering used by every data port of a multi-port memory controller and by the controller's external memory side. One global big-endian control sets the ordering for the whole controller. Each port also has a byte-strobe enable, and a port built 64 bits wide can use it to run in mixed-endian mode, where the master's byte strobes pick the active lanes. Ports built 32 bits wide have no mixed mode. When the global control is high, big-endian ordering applies everywhere and the strobe enables have no effect.

The reset value of the global control comes from a strap input. The strobe enables are captured while reset is asserted and stay fixed after that. Software can change the global ordering at run time with a configuration write. The write does not take effect at once: the block holds it as pending, asks for a flush of buffered data, and applies the new ordering only after the flush is acknowledged. A small datapath for port 0 takes the port's resolved mode and computes the active byte lanes and the byte order of the write data that goes toward memory.

Top module: `endian_mode_resolver`

## Requirements
- R1: A 32-bit port (WIDE_MASK bit clear) resolves to little-endian when the global control is low and to big-endian when it is high. It never resolves to mixed.
- R2: While the global control is high, every port and the memory side resolve to big-endian, whatever the strobe enables are.
- R3: While the global control is low, a 64-bit port resolves to little-endian if its captured strobe enable is 0 and to mixed-endian if it is 1.
- R4: The memory side resolves to little-endian when the global control is low and to big-endian when it is high. Mode encoding on port_mode (port p at bits [2p+1:2p]) and mem_mode: 2'b00 little, 2'b01 mixed, 2'b10 big.
- R5: During reset the global control loads from strap_big and the strobe enables load from strb_en_in. After reset, changes on these inputs have no effect.
- R6: A cfg_wr_en write whose cfg_wr_big differs from the current global control sets a pending change and raises flush_req in the next cycle. The modes stay as they are until flush_ack is sampled high with the change pending. The new modes and a low flush_req appear in the following cycle. A write equal to the current setting with nothing pending raises no request.
- R7: Once raised, flush_req stays high until flush_ack is sampled.
- R8: When port 0 is mixed, dp_lane_en equals dp_strb, whatever the value of dp_unalign.
- R9: When port 0 is little or big and dp_unalign is 0, dp_lane_en covers 2^dp_size contiguous bytes starting at dp_addr rounded down to a multiple of 2^dp_size. When dp_unalign is 1 in these modes, dp_lane_en is all zero.
- R10: When port 0 is big, output byte k of dp_mdata is input byte (unit base + 2^dp_size - 1 - offset) of dp_wdata, so bytes are reversed inside each unit of 2^dp_size bytes. In little or mixed mode the data passes through unchanged.
- R11: A flush_ack with no pending change has no effect on the modes or on flush_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_big | input | 1 | Reset value of the global big-endian control |
| strb_en_in | input | NUM_PORTS | Per-port byte-strobe enables, captured during reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_big | input | 1 | Requested global big-endian value |
| flush_ack | input | 1 | Flush-complete acknowledge |
| flush_req | output | 1 | Flush request for a pending change |
| port_mode | output | 2*NUM_PORTS | Resolved mode of each port |
| mem_mode | output | 2 | Resolved mode of the memory side |
| dp_size | input | 2 | Access size of port 0 (log2 of bytes) |
| dp_addr | input | log2(DP_BYTES) | Low address bits of port 0 |
| dp_strb | input | DP_BYTES | Byte strobes of port 0 |
| dp_unalign | input | 1 | Unaligned-transfer flag of port 0 |
| dp_wdata | input | 8*DP_BYTES | Port 0 write data |
| dp_lane_en | output | DP_BYTES | Active byte lanes toward memory |
| dp_mdata | output | 8*DP_BYTES | Byte-ordered data toward memory |

## Verification
The bound checker checks the following on every cycle:
- A big memory side always comes with every port big.
- A narrow port never reports mixed, and the memory side never reports mixed.
- The memory mode changes only after a flush request has been acknowledged.
- The request holds until it is acknowledged.
- In mixed mode the active lanes follow the strobes.

The bench scenarios cover the rest:
- The full strap and strobe-enable sweep, and the fact that strobe enables are frozen after reset.
- Exact lane masks and byte reversal for every size, address and unaligned flag, in all three modes.
- That an equal write or a stray acknowledge does nothing.

// File: rtl/endian_pkg.sv
// Package: shared mode encoding for the endianness resolver.
// Assumes: encoding is visible at the top-level ports and must stay fixed.
package endian_pkg;
    typedef enum logic [1:0] {
        MODE_LITTLE = 2'b00,
        MODE_MIXED  = 2'b01,
        MODE_BIG    = 2'b10
    } mode_e;
endpackage

// File: rtl/endian_mode_ctrl.sv
// endian_mode_ctrl: holds the global big-endian setting and the captured
// strobe enables, and runs the pending-change / flush handshake.
// Assumes: strap and strobe enables are stable while rst_n is low; a write
// arriving in the same cycle as an accepted acknowledge is dropped.
module endian_mode_ctrl #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_big_i,
    input  logic [NUM_PORTS-1:0] strb_en_i,
    input  logic                 wr_en_i,
    input  logic                 wr_big_i,
    input  logic                 flush_ack_i,
    output logic                 global_big_o,
    output logic [NUM_PORTS-1:0] strb_en_o,
    output logic                 flush_req_o
);
    logic                 global_big_q;
    logic [NUM_PORTS-1:0] strb_en_q;
    logic                 pend_q;
    logic                 pend_val_q;
    logic                 ack_take;
    logic                 wr_take;

    // Decide whether an acknowledge or a write is accepted this cycle.
    always_comb begin
        ack_take = pend_q && flush_ack_i;
        wr_take  = !ack_take && wr_en_i && (pend_q || (wr_big_i != global_big_q));
    end

    // Capture straps in reset; afterwards apply pending change on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            global_big_q <= strap_big_i;
            strb_en_q    <= strb_en_i;
            pend_q       <= 1'b0;
            pend_val_q   <= 1'b0;
        end else if (ack_take) begin
            global_big_q <= pend_val_q;
            pend_q       <= 1'b0;
        end else if (wr_take) begin
            pend_q       <= 1'b1;
            pend_val_q   <= wr_big_i;
        end
    end

    // Drive the outputs from the held state.
    always_comb begin
        global_big_o = global_big_q;
        strb_en_o    = strb_en_q;
        flush_req_o  = pend_q;
    end
endmodule

// File: rtl/endian_port_resolve.sv
// endian_port_resolve: maps the global control and one port's strobe enable
// to that port's byte-ordering mode.
// Assumes: WIDE is fixed at build time (1 = 64-bit port, 0 = 32-bit port).
module endian_port_resolve
    import endian_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic  global_big_i,
    input  logic  strb_en_i,
    output mode_e mode_o
);
    // Global big overrides; mixed only exists on wide ports.
    always_comb begin
        if (global_big_i)
            mode_o = MODE_BIG;
        else if (WIDE && strb_en_i)
            mode_o = MODE_MIXED;
        else
            mode_o = MODE_LITTLE;
    end
endmodule

// File: rtl/endian_lane_swap.sv
// endian_lane_swap: computes active byte lanes and byte order for one port.
// Assumes: size is log2 of the access bytes and never exceeds log2(BYTES).
module endian_lane_swap
    import endian_pkg::*;
#(
    parameter int BYTES = 8,
    localparam int AW   = $clog2(BYTES),
    localparam int DW   = 8 * BYTES
) (
    input  mode_e             mode_i,
    input  logic [1:0]        size_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [BYTES-1:0]  strb_i,
    input  logic              unalign_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [BYTES-1:0]  lane_en_o,
    output logic [DW-1:0]     mdata_o
);
    logic [AW-1:0]    unit_mask;
    logic [AW-1:0]    base;
    logic [BYTES-1:0] nat_lanes;

    // Derive the in-unit offset mask and the aligned base of the access.
    always_comb begin
        unit_mask = AW'((32'd1 << size_i) - 32'd1);
        base      = addr_i & ~unit_mask;
    end

    // Build the natural lane mask for an aligned access.
    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            nat_lanes[i] = ((AW'(i) & ~unit_mask) == base);
        end
    end

    // Select lanes: strobes in mixed mode, else aligned mask or none.
    always_comb begin
        if (mode_i == MODE_MIXED)
            lane_en_o = strb_i;
        else if (unalign_i)
            lane_en_o = '0;
        else
            lane_en_o = nat_lanes;
    end

    // Per-lane byte steering: reverse within the unit in big mode.
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [AW-1:0] src;
        always_comb begin
            src = (mode_i == MODE_BIG) ? (AW'(g) ^ unit_mask) : AW'(g);
            mdata_o[8*g +: 8] = wdata_i[8*src +: 8];
        end
    end
endmodule

// File: rtl/endian_mode_resolver.sv
// endian_mode_resolver: top level. Resolves per-port and memory-side
// byte ordering and steers port 0 data.
// Assumes: port 0 is the datapath port; WIDE_MASK bit p set means port p is
// 64 bits wide.
module endian_mode_resolver
    import endian_pkg::*;
#(
    parameter int             NUM_PORTS = 4,
    parameter logic [NUM_PORTS-1:0] WIDE_MASK = 4'b0011,
    parameter int             DP_BYTES  = 8,
    localparam int            AW        = $clog2(DP_BYTES),
    localparam int            DW        = 8 * DP_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strap_big,
    input  logic [NUM_PORTS-1:0]   strb_en_in,
    input  logic                   cfg_wr_en,
    input  logic                   cfg_wr_big,
    input  logic                   flush_ack,
    output logic                   flush_req,
    output logic [2*NUM_PORTS-1:0] port_mode,
    output logic [1:0]             mem_mode,
    input  logic [1:0]             dp_size,
    input  logic [AW-1:0]          dp_addr,
    input  logic [DP_BYTES-1:0]    dp_strb,
    input  logic                   dp_unalign,
    input  logic [DW-1:0]          dp_wdata,
    output logic [DP_BYTES-1:0]    dp_lane_en,
    output logic [DW-1:0]          dp_mdata
);
    logic                 global_big;
    logic [NUM_PORTS-1:0] strb_en_cap;
    mode_e                mode_arr [NUM_PORTS];

    endian_mode_ctrl #(.NUM_PORTS(NUM_PORTS)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_big_i  (strap_big),
        .strb_en_i    (strb_en_in),
        .wr_en_i      (cfg_wr_en),
        .wr_big_i     (cfg_wr_big),
        .flush_ack_i  (flush_ack),
        .global_big_o (global_big),
        .strb_en_o    (strb_en_cap),
        .flush_req_o  (flush_req)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        endian_port_resolve #(.WIDE(WIDE_MASK[p])) res_i (
            .global_big_i (global_big),
            .strb_en_i    (strb_en_cap[p]),
            .mode_o       (mode_arr[p])
        );
        // Pack this port's mode onto the output bus.
        always_comb port_mode[2*p +: 2] = mode_arr[p];
    end

    // Memory side follows the global control only.
    always_comb mem_mode = global_big ? MODE_BIG : MODE_LITTLE;

    endian_lane_swap #(.BYTES(DP_BYTES)) swap_i (
        .mode_i    (mode_arr[0]),
        .size_i    (dp_size),
        .addr_i    (dp_addr),
        .strb_i    (dp_strb),
        .unalign_i (dp_unalign),
        .wdata_i   (dp_wdata),
        .lane_en_o (dp_lane_en),
        .mdata_o   (dp_mdata)
    );
endmodule

// File: rtl/endian_mode_resolver_chk.sv
// endian_mode_resolver_chk: cycle-level properties of the resolver,
// bound onto every instance of the top module.
module endian_mode_resolver_chk #(
    parameter int NUM_PORTS = 4,
    parameter logic [NUM_PORTS-1:0] WIDE_MASK = 4'b0011,
    parameter int DP_BYTES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   flush_ack,
    input logic                   flush_req,
    input logic [2*NUM_PORTS-1:0] port_mode,
    input logic [1:0]             mem_mode,
    input logic [DP_BYTES-1:0]    dp_strb,
    input logic [DP_BYTES-1:0]    dp_lane_en
);
    // R2: a big memory side means every port is big.
    a_r2_all_big: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_mode == 2'b10) |-> (port_mode == {NUM_PORTS{2'b10}}));

    // R4: the memory side is never mixed.
    a_r4_mem_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mem_mode != 2'b01);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
        if (!WIDE_MASK[p]) begin : g_narrow
            // R1: a narrow port never resolves to mixed.
            a_r1_narrow_not_mixed: assert property (@(posedge clk) disable iff (!rst_n)
                port_mode[2*p +: 2] != 2'b01);
        end
        // R3: a port is big only together with the memory side.
        a_r3_port_big_global: assert property (@(posedge clk) disable iff (!rst_n)
            (port_mode[2*p +: 2] == 2'b10) |-> (mem_mode == 2'b10));
    end

    // R6: the memory mode changes only after an acknowledged request.
    a_r6_change_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (mem_mode != $past(mem_mode))) |-> ($past(flush_req) && $past(flush_ack)));

    // R7: the request holds until acknowledged.
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req);

    // R8: in mixed mode the active lanes are the strobes.
    a_r8_mixed_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (port_mode[1:0] == 2'b01) |-> (dp_lane_en == dp_strb));
endmodule

bind endian_mode_resolver endian_mode_resolver_chk #(
    .NUM_PORTS (NUM_PORTS),
    .WIDE_MASK (WIDE_MASK),
    .DP_BYTES  (DP_BYTES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_ack  (flush_ack),
    .flush_req  (flush_req),
    .port_mode  (port_mode),
    .mem_mode   (mem_mode),
    .dp_strb    (dp_strb),
    .dp_lane_en (dp_lane_en)
);

// File: tb/endian_mode_resolver_tb_top.sv
// Bench: sweeps straps, strobe enables and the port 0 datapath in all modes.
module endian_mode_resolver_tb_top;
    localparam int NP = 4;
    localparam logic [NP-1:0] WIDE = 4'b0011;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap_big = 1'b0;
    logic [NP-1:0] strb_en_in = '0;
    logic          cfg_wr_en = 1'b0;
    logic          cfg_wr_big = 1'b0;
    logic          flush_ack = 1'b0;
    logic          flush_req;
    logic [2*NP-1:0] port_mode;
    logic [1:0]    mem_mode;
    logic [1:0]    dp_size = '0;
    logic [2:0]    dp_addr = '0;
    logic [NB-1:0] dp_strb = '0;
    logic          dp_unalign = 1'b0;
    logic [8*NB-1:0] dp_wdata = '0;
    logic [NB-1:0] dp_lane_en;
    logic [8*NB-1:0] dp_mdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    endian_mode_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .strap_big(strap_big), .strb_en_in(strb_en_in),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_big(cfg_wr_big), .flush_ack(flush_ack),
        .flush_req(flush_req), .port_mode(port_mode), .mem_mode(mem_mode),
        .dp_size(dp_size), .dp_addr(dp_addr), .dp_strb(dp_strb), .dp_unalign(dp_unalign),
        .dp_wdata(dp_wdata), .dp_lane_en(dp_lane_en), .dp_mdata(dp_mdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2*NP-1:0] exp_modes(input bit g, input logic [NP-1:0] s);
        logic [2*NP-1:0] r;
        for (int p = 0; p < NP; p++)
            r[2*p +: 2] = g ? 2'd2 : ((WIDE[p] && s[p]) ? 2'd1 : 2'd0);
        return r;
    endfunction

    task automatic do_reset(input bit g, input logic [NP-1:0] s);
        @(negedge clk);
        rst_n = 1'b0; strap_big = g; strb_en_in = s;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // mode: 0 little, 1 mixed, 2 big
    task automatic dp_sweep(input int mode, input string tag);
        logic [NB-1:0] strbs [4] = '{8'hFF, 8'h0F, 8'h3C, 8'h81};
        for (int sz = 0; sz < 4; sz++)
            for (int a = 0; a < NB; a++)
                for (int u = 0; u < 2; u++)
                    for (int k = 0; k < 4; k++) begin
                        int n;
                        logic [NB-1:0] el;
                        logic [63:0] ed;
                        dp_size = 2'(sz); dp_addr = 3'(a); dp_unalign = u[0];
                        dp_strb = strbs[k];
                        dp_wdata = 64'h8877665544332211 ^ {8{8'(a*16 + k)}};
                        #1;
                        n = 1 << sz;
                        if (mode == 1) el = dp_strb;
                        else if (u == 1) el = '0;
                        else for (int i = 0; i < NB; i++) el[i] = (i >= (a/n)*n) && (i < (a/n)*n + n);
                        for (int i = 0; i < NB; i++) begin
                            int src;
                            src = (mode == 2) ? ((i/n)*n + (n - 1 - (i%n))) : i;
                            ed[8*i +: 8] = dp_wdata[8*src +: 8];
                        end
                        chk(dp_lane_en == el, (mode == 1) ? "R8 lanes" : {tag, " R9 lanes"}, 64'(dp_lane_en), 64'(el));
                        chk(dp_mdata == ed, {tag, " R10 data"}, dp_mdata, ed);
                    end
    endtask

    task automatic cfg_write(input bit v);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_big = v;
        @(negedge clk); cfg_wr_en = 1'b0;
    endtask

    task automatic pulse_ack;
        @(negedge clk); flush_ack = 1'b1;
        @(negedge clk); flush_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 R2 R3 R4 R5: full strap and strobe-enable sweep
        for (int g = 0; g < 2; g++)
            for (int s = 0; s < 16; s++) begin
                logic [2*NP-1:0] em;
                do_reset(g[0], 4'(s));
                em = exp_modes(g[0], 4'(s));
                chk(port_mode == em, "R1/R2/R3 port modes", 64'(port_mode), 64'(em));
                chk(mem_mode == (g ? 2'd2 : 2'd0), "R4 mem mode", 64'(mem_mode), 64'(g ? 2 : 0));
                chk(flush_req == 1'b0, "R7 reset req", 64'(flush_req), 64'd0);
                strb_en_in = ~4'(s); strap_big = ~g[0];
                repeat (2) @(negedge clk);
                chk(port_mode == em, "R5 frozen enables", 64'(port_mode), 64'(em));
                chk(mem_mode == (g ? 2'd2 : 2'd0), "R5 frozen strap", 64'(mem_mode), 64'(g ? 2 : 0));
            end

        do_reset(1'b0, 4'b0000);
        dp_sweep(0, "little");

        do_reset(1'b0, 4'b0001);
        dp_sweep(1, "mixed");

        // R11: stray acknowledge
        pulse_ack();
        chk(port_mode == exp_modes(1'b0, 4'b0001), "R11 stray ack modes", 64'(port_mode), 64'(exp_modes(1'b0, 4'b0001)));
        chk(flush_req == 1'b0, "R11 stray ack req", 64'(flush_req), 64'd0);

        // R6: equal write raises nothing
        cfg_write(1'b0);
        chk(flush_req == 1'b0, "R6 equal write", 64'(flush_req), 64'd0);

        // R6 R7: change to big held until acknowledge
        cfg_write(1'b1);
        chk(flush_req == 1'b1, "R6 req raised", 64'(flush_req), 64'd1);
        repeat (3) @(negedge clk);
        chk(flush_req == 1'b1, "R7 req held", 64'(flush_req), 64'd1);
        chk(mem_mode == 2'd0, "R6 no early change", 64'(mem_mode), 64'd0);
        chk(port_mode[1:0] == 2'd1, "R6 port held", 64'(port_mode[1:0]), 64'd1);
        pulse_ack();
        chk(mem_mode == 2'd2, "R6 applied mem", 64'(mem_mode), 64'd2);
        chk(port_mode == exp_modes(1'b1, 4'b0001), "R2 applied ports", 64'(port_mode), 64'(exp_modes(1'b1, 4'b0001)));
        chk(flush_req == 1'b0, "R6 req dropped", 64'(flush_req), 64'd0);
        dp_sweep(2, "big");

        // R3: return to little restores mixed on port 0
        cfg_write(1'b0);
        pulse_ack();
        chk(port_mode == exp_modes(1'b0, 4'b0001), "R3 back to mixed", 64'(port_mode), 64'(exp_modes(1'b0, 4'b0001)));
        chk(mem_mode == 2'd0, "R4 back to little", 64'(mem_mode), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule